// File: doc/BRIEF.md
# Register-Driven SPI Command Engine

This block runs one SPI flash transaction at a time, described by a handful of byte-wide registers. A host uses a single address/data strobe interface. It queues the command byte and its payload into a transmit queue register, sets a packed length register, and then sets the start bit of the control register. The engine drops chip select and clocks out the command byte and the payload. Unless the host asked for no response, it then clocks in the requested number of bytes into a receive buffer. The host drains that buffer through a receive register, one byte per read.

The serial side uses SPI mode 0. The clock idles low, data changes on the falling edge and is sampled on the rising edge, and bits go out most significant bit first. Each half clock period lasts `HALF_DIV` system clocks. The register offsets are fixed:

- 0x90: transmit queue.
- 0x91: receive data.
- 0x92: length.
- 0x93: control.

Bit positions inside the length and control registers are part of the host contract.

Top module: `spi_cmd_engine`

## Requirements
- R1: After synchronous reset, `spi_cs_n` is 1, `spi_sclk` is 0, `spi_mosi` is 0, `reg_rdata` is 0, and control (0x93) reads 0x00.
- R2: The length register (0x92) reads back the last value written. Control (0x93) reads back as follows: bits 4:2 as last written, bit 1 always 0, bit 0 the running flag, bits 7:5 as 0.
- R3: A transaction first sends transmit-queue entry 0 (the command byte), then entries 1 through N in order, where N is length bits 3:0. Every byte goes out MSB first.
- R4: While chip select is low, each bit holds `spi_sclk` low for `HALF_DIV` cycles, then high for `HALF_DIV` cycles. `spi_mosi` changes only as `spi_sclk` falls or as chip select changes. Chip select falls one cycle after the start write is captured, and `spi_sclk` is 0 whenever chip select is high.
- R5: Unless no-read is set, the command and payload are followed by (length bits 7:4) + 1 received bytes. The engine samples `spi_miso` on each rising `spi_sclk`, MSB first, and drives `spi_mosi` to 0 during this phase.
- R6: When control bit 2 is 1 in the start write, the receive phase is skipped. Only the command and payload bytes are clocked, and the receive buffer keeps its contents.
- R7: Writing control with bit 0 set starts a transaction. Bit 0 reads 1 while it runs and 0 afterwards. Chip select rises on the same clock as the last falling `spi_sclk`.
- R8: Successive reads of 0x91 return the received bytes in order, starting from the first byte of the latest transaction. The read pointer wraps after `DEPTH` reads.
- R9: While a transaction runs, writes to 0x90, 0x92 and 0x93 have no effect.
- R10: Writing control with bit 1 set empties the transmit queue and rewinds the receive read pointer. The next queued byte becomes the command byte.
- R11: Reading 0x90 returns the number of queued bytes. The queue holds at most `DEPTH` bytes, and further writes are dropped. The count returns to 0 when a transaction ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_re | input | 1 | Read strobe, one cycle per read |
| reg_rdata | output | 8 | Registered read data, valid the cycle after `reg_re` |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench checks every clock against a behavioural model, including a transfer that is full in both directions (16 out, 16 in). A design that drops one byte or miscounts the read length by one would leave chip select low for the wrong number of cycles.

Other cases the bench targets, and how a wrong design would show them:
- A no-read start: a design that ignored the bit would keep clocking past the command byte.
- Writes issued while busy: a design that accepted them would corrupt the length or the queue count.
- A seventeenth queued byte: it would overflow the queue.
- Read-pointer wrap, and rewinding after a clear: an off-by-one pointer would return the wrong received byte.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

  localparam logic [7:0] REG_TXQ  = 8'h90;
  localparam logic [7:0] REG_RXQ  = 8'h91;
  localparam logic [7:0] REG_LEN  = 8'h92;
  localparam logic [7:0] REG_CTRL = 8'h93;

  localparam int CB_GO   = 0;
  localparam int CB_CLR  = 1;
  localparam int CB_NORD = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_TX   = 2'd1,
    SEQ_RX   = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [3:0] rd_m1;
    logic [3:0] wr_n;
  } len_field_t;

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [7:0]               reg_addr,
  input  logic [7:0]               reg_wdata,
  input  logic                     reg_we,
  input  logic                     reg_re,
  output logic [7:0]               reg_rdata,
  input  logic                     busy,
  input  logic                     done,
  input  logic [$clog2(DEPTH)-1:0] tx_idx,
  output logic [7:0]               tx_byte,
  input  logic                     rx_we,
  input  logic [7:0]               rx_byte,
  output logic                     start,
  output logic                     start_nord,
  output len_field_t               len_q
);

  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;

  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [CW-1:0] wr_cnt;
  logic [IW-1:0] rx_wp;
  logic [IW-1:0] rd_ptr;
  logic          nord_q, rbk_q, mode_q;
  logic          idle_we, wr_txq, wr_len, wr_ctrl, rd_rxq, clr, q_room;

  assign idle_we    = reg_we && !busy;
  assign wr_txq     = idle_we && (reg_addr == REG_TXQ);
  assign wr_len     = idle_we && (reg_addr == REG_LEN);
  assign wr_ctrl    = idle_we && (reg_addr == REG_CTRL);
  assign rd_rxq     = reg_re && (reg_addr == REG_RXQ);
  assign clr        = wr_ctrl && reg_wdata[CB_CLR];
  assign start      = wr_ctrl && reg_wdata[CB_GO];
  assign start_nord = reg_wdata[CB_NORD];
  assign q_room     = wr_cnt < CW'(DEPTH);

  // transmit queue: synchronous write, indexed read by the sequencer
  always_ff @(posedge clk) begin
    if (wr_txq && q_room) tx_mem[wr_cnt[IW-1:0]] <= reg_wdata;
  end
  assign tx_byte = tx_mem[tx_idx];

  // receive buffer: synchronous write, registered read below
  always_ff @(posedge clk) begin
    if (rx_we) rx_mem[rx_wp] <= rx_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_cnt <= '0;
      rx_wp  <= '0;
      rd_ptr <= '0;
      len_q  <= '0;
      nord_q <= 1'b0;
      rbk_q  <= 1'b0;
      mode_q <= 1'b0;
    end else begin
      if (clr || done)           wr_cnt <= '0;
      else if (wr_txq && q_room) wr_cnt <= wr_cnt + 1'b1;
      if (wr_len)  len_q <= len_field_t'(reg_wdata);
      if (wr_ctrl) {mode_q, rbk_q, nord_q} <= reg_wdata[4:2];
      if (start)      rx_wp <= '0;
      else if (rx_we) rx_wp <= rx_wp + 1'b1;
      if (start || clr) rd_ptr <= '0;
      else if (rd_rxq)  rd_ptr <= rd_ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_re) begin
      case (reg_addr)
        REG_TXQ:  reg_rdata <= 8'(wr_cnt);
        REG_RXQ:  reg_rdata <= rx_mem[rd_ptr];
        REG_LEN:  reg_rdata <= len_q;
        REG_CTRL: reg_rdata <= {3'b000, mode_q, rbk_q, nord_q, 1'b0, busy};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  // R11
  q_bound_chk: assert property (@(posedge clk) disable iff (rst)
    wr_cnt <= CW'(DEPTH));

  // R11
  q_empty_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (wr_cnt == '0));

  // R9
  busy_len_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_we) |=> $stable(len_q));

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic [7:0] load_byte,
  input  logic       sh_fall,
  input  logic       sh_rise,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] rx_sr
);

  logic [7:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sr <= '0;
      rx_sr <= '0;
    end else begin
      if (load)         tx_sr <= load_byte;
      else if (sh_fall) tx_sr <= {tx_sr[6:0], 1'b0};
      if (sh_rise)      rx_sr <= {rx_sr[6:0], miso};
    end
  end

  assign mosi = tx_sr[7];

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     start_nord,
  input  len_field_t               len_q,
  input  logic [7:0]               tx_byte,
  output logic [$clog2(DEPTH)-1:0] tx_idx,
  output logic                     busy,
  output logic                     done,
  output logic                     rx_we,
  output logic                     load,
  output logic [7:0]               load_byte,
  output logic                     sh_rise,
  output logic                     sh_fall,
  output logic                     cs_n,
  output logic                     sclk
);

  localparam int IW = $clog2(DEPTH);
  localparam int BW = $clog2(2 * DEPTH + 1);
  localparam int HW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  seq_state_e    st;
  logic [HW-1:0] hc;
  logic [2:0]    bit_q;
  logic [BW-1:0] byte_q, n_wr, n_tot, nxt_byte, new_wr, new_rd;
  logic          tick, byte_end, last, nxt_is_tx;

  assign busy      = (st != SEQ_IDLE);
  assign tick      = busy && (hc == HW'(HALF_DIV - 1));
  assign sh_rise   = tick && !sclk;
  assign sh_fall   = tick && sclk;
  assign byte_end  = sh_fall && (bit_q == 3'd7);
  assign nxt_byte  = byte_q + 1'b1;
  assign last      = byte_end && (nxt_byte == n_tot);
  assign nxt_is_tx = nxt_byte < n_wr;
  assign done      = last;
  assign rx_we     = byte_end && (st == SEQ_RX);
  assign tx_idx    = busy ? nxt_byte[IW-1:0] : '0;
  assign load      = start || byte_end;
  assign load_byte = (start || (byte_end && !last && nxt_is_tx)) ? tx_byte : 8'h00;
  assign new_wr    = BW'(len_q.wr_n) + 1'b1;
  assign new_rd    = start_nord ? '0 : (BW'(len_q.rd_m1) + 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= SEQ_IDLE;
      hc     <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b1;
      bit_q  <= '0;
      byte_q <= '0;
      n_wr   <= '0;
      n_tot  <= '0;
    end else if (start) begin
      st     <= SEQ_TX;
      hc     <= '0;
      sclk   <= 1'b0;
      cs_n   <= 1'b0;
      bit_q  <= '0;
      byte_q <= '0;
      n_wr   <= new_wr;
      n_tot  <= new_wr + new_rd;
    end else if (busy) begin
      if (tick) begin
        hc   <= '0;
        sclk <= !sclk;
        if (sh_fall) begin
          if (byte_end) begin
            bit_q <= '0;
            if (last) begin
              st   <= SEQ_IDLE;
              cs_n <= 1'b1;
            end else begin
              byte_q <= nxt_byte;
              st     <= nxt_is_tx ? SEQ_TX : SEQ_RX;
            end
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end

  // R4
  idle_clock_low_chk: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R7
  end_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> $fell(sclk));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] reg_addr,
  input  logic [7:0] reg_wdata,
  input  logic       reg_we,
  input  logic       reg_re,
  output logic [7:0] reg_rdata,
  output logic       spi_cs_n,
  output logic       spi_sclk,
  output logic       spi_mosi,
  input  logic       spi_miso
);

  localparam int IW = $clog2(DEPTH);

  logic          busy, done, start, start_nord, rx_we, load, sh_rise, sh_fall;
  logic [IW-1:0] tx_idx;
  logic [7:0]    tx_byte, load_byte, rx_sr;
  len_field_t    len_q;

  spi_cmd_regs #(.DEPTH(DEPTH)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_we     (reg_we),
    .reg_re     (reg_re),
    .reg_rdata  (reg_rdata),
    .busy       (busy),
    .done       (done),
    .tx_idx     (tx_idx),
    .tx_byte    (tx_byte),
    .rx_we      (rx_we),
    .rx_byte    (rx_sr),
    .start      (start),
    .start_nord (start_nord),
    .len_q      (len_q)
  );

  spi_cmd_seq #(.DEPTH(DEPTH), .HALF_DIV(HALF_DIV)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_nord (start_nord),
    .len_q      (len_q),
    .tx_byte    (tx_byte),
    .tx_idx     (tx_idx),
    .busy       (busy),
    .done       (done),
    .rx_we      (rx_we),
    .load       (load),
    .load_byte  (load_byte),
    .sh_rise    (sh_rise),
    .sh_fall    (sh_fall),
    .cs_n       (spi_cs_n),
    .sclk       (spi_sclk)
  );

  spi_cmd_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_byte (load_byte),
    .sh_fall   (sh_fall),
    .sh_rise   (sh_rise),
    .miso      (spi_miso),
    .mosi      (spi_mosi),
    .rx_sr     (rx_sr)
  );

  // R4
  mosi_edge_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(spi_mosi) |-> ($fell(spi_sclk) || !$stable(spi_cs_n)));

endmodule

// File: tb/sim_spi_cmd_engine.sv
module sim_spi_cmd_engine;

  localparam int HALF = 2;
  localparam logic [7:0] A_TXQ  = 8'h90;
  localparam logic [7:0] A_RXQ  = 8'h91;
  localparam logic [7:0] A_LEN  = 8'h92;
  localparam logic [7:0] A_CTRL = 8'h93;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic       reg_re = 1'b0;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_sclk, spi_mosi;
  logic       spi_miso = 1'b1;

  always #5 clk = ~clk;

  spi_cmd_engine #(.DEPTH(16), .HALF_DIV(HALF)) u0 (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic [7:0] m_tx [16];
  logic [7:0] m_rx [16];
  logic [7:0] m_resp [16];
  int         m_wcnt, m_rp, m_k, m_nw, m_nr;
  bit         m_busy, m_nord, m_rbk, m_mode;
  logic [7:0] m_len, m_rdata;
  string      m_tag = "R1";

  always @(posedge clk) begin
    if (rst) begin
      m_wcnt = 0; m_rp = 0; m_k = 0; m_nw = 0; m_nr = 0;
      m_busy = 0; m_nord = 0; m_rbk = 0; m_mode = 0;
      m_len = 0; m_rdata = 0; m_tag = "R1";
    end else begin
      if (reg_re) begin
        case (reg_addr)
          A_TXQ:  begin m_rdata = 8'(m_wcnt); m_tag = "R11"; end
          A_RXQ:  begin m_rdata = m_rx[m_rp]; m_rp = (m_rp + 1) % 16; m_tag = "R8"; end
          A_LEN:  begin m_rdata = m_len; m_tag = "R2"; end
          A_CTRL: begin m_rdata = {3'b000, m_mode, m_rbk, m_nord, 1'b0, m_busy}; m_tag = "R7"; end
          default: begin m_rdata = 0; m_tag = "R2"; end
        endcase
      end
      if (m_busy) begin
        m_k++;
        if (m_k == 16 * (m_nw + m_nr) * HALF) begin
          m_busy = 0;
          m_wcnt = 0;
          for (int i = 0; i < m_nr; i++) m_rx[i] = m_resp[i];
        end
      end else if (reg_we) begin
        case (reg_addr)
          A_TXQ: if (m_wcnt < 16) begin m_tx[m_wcnt] = reg_wdata; m_wcnt++; end
          A_LEN: m_len = reg_wdata;
          A_CTRL: begin
            m_nord = reg_wdata[2]; m_rbk = reg_wdata[3]; m_mode = reg_wdata[4];
            if (reg_wdata[1]) begin m_wcnt = 0; m_rp = 0; end
            if (reg_wdata[0]) begin
              m_busy = 1; m_k = 0; m_rp = 0;
              m_nw = int'(m_len[3:0]) + 1;
              m_nr = m_nord ? 0 : int'(m_len[7:4]) + 1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // per-clock comparison and slave response
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      logic [2:0] exp_pins;
      int h, b, by;
      exp_pins = 3'b100;
      if (m_busy) begin
        h = m_k / HALF; b = h / 2; by = b / 8;
        exp_pins = {1'b0, 1'(h % 2), (by < m_nw) ? m_tx[by][7 - b % 8] : 1'b0};
      end
      chk("R4 pins {cs_n,sclk,mosi}", int'({spi_cs_n, spi_sclk, spi_mosi}), int'(exp_pins));
      chk(m_tag, int'(reg_rdata), int'(m_rdata));
    end
    spi_miso = 1'b1;
    if (m_busy) begin
      int b2, by2;
      b2 = (m_k / HALF) / 2; by2 = b2 / 8;
      if (by2 >= m_nw && by2 < m_nw + m_nr) spi_miso = m_resp[by2 - m_nw][7 - b2 % 8];
    end
  end

  // independent capture of bits sent at rising sclk
  bit cap[$];
  initial forever begin
    @(posedge spi_sclk);
    cap.push_back(spi_mosi);
  end

  function automatic logic [7:0] cap_byte(input int i);
    logic [7:0] v;
    for (int j = 0; j < 8; j++) v[7 - j] = cap[i * 8 + j];
    return v;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_re = 1'b1;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int n = 0; n < 5000; n++) begin
      rd(A_CTRL, v);
      if (!v[0]) break;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R7: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset pins", int'({spi_cs_n, spi_sclk, spi_mosi}), 3'b100);
    chk("R1 reset rdata", int'(reg_rdata), 0);
    rd(A_CTRL, v); chk("R1 ctrl after reset", v, 8'h00);

    wr(A_LEN, 8'h32); rd(A_LEN, v); chk("R2 len readback", v, 8'h32);
    wr(A_CTRL, 8'h1A); rd(A_CTRL, v); chk("R2 ctrl readback", v, 8'h18);
    rd(A_TXQ, v); chk("R10 clear leaves queue empty", v, 0);

    // transaction with payload and two-byte response
    wr(A_TXQ, 8'h03); wr(A_TXQ, 8'hA5); wr(A_TXQ, 8'h5A); wr(A_TXQ, 8'h01);
    rd(A_TXQ, v); chk("R11 queue count", v, 4);
    wr(A_LEN, 8'h13);
    m_resp[0] = 8'hC3; m_resp[1] = 8'h3C;
    cap.delete();
    wr(A_CTRL, 8'h01);
    rd(A_CTRL, v); chk("R7 running flag", v, 8'h01);
    wait_idle();
    rd(A_CTRL, v); chk("R7 flag cleared", v, 8'h00);
    chk("R5 bit count", cap.size(), 48);
    chk("R3 command byte", cap_byte(0), 8'h03);
    chk("R3 payload byte 3", cap_byte(3), 8'h01);
    chk("R5 mosi low in read phase", cap_byte(4), 8'h00);
    rd(A_RXQ, v); chk("R5 response byte 0", v, 8'hC3);
    rd(A_RXQ, v); chk("R8 response byte 1", v, 8'h3C);

    // no-read transaction
    wr(A_TXQ, 8'h06); wr(A_LEN, 8'h70);
    cap.delete();
    wr(A_CTRL, 8'h05);
    wait_idle();
    chk("R6 only command clocked", cap.size(), 8);
    chk("R6 command byte", cap_byte(0), 8'h06);
    rd(A_RXQ, v); chk("R6 buffer untouched", v, 8'hC3);
    rd(A_CTRL, v); chk("R2 no-read bit stored", v, 8'h04);

    // writes while busy
    wr(A_TXQ, 8'h0B); wr(A_TXQ, 8'h11); wr(A_LEN, 8'h01);
    m_resp[0] = 8'h96;
    cap.delete();
    wr(A_CTRL, 8'h01);
    wr(A_TXQ, 8'hEE); wr(A_LEN, 8'hFF); wr(A_CTRL, 8'h1E);
    wait_idle();
    rd(A_LEN, v);  chk("R9 length unchanged", v, 8'h01);
    rd(A_TXQ, v);  chk("R9 queue not filled", v, 0);
    rd(A_CTRL, v); chk("R9 control unchanged", v, 8'h00);
    rd(A_RXQ, v);  chk("R5 single response", v, 8'h96);
    chk("R3 payload after busy writes", cap_byte(1), 8'h11);

    // full queue and full response
    for (int i = 0; i < 17; i++) wr(A_TXQ, 8'(i * 17 + 1));
    rd(A_TXQ, v); chk("R11 queue saturates", v, 16);
    for (int i = 0; i < 16; i++) m_resp[i] = 8'(8'hF0 ^ (i * 3));
    wr(A_LEN, 8'hFF);
    cap.delete();
    wr(A_CTRL, 8'h01);
    wait_idle();
    chk("R5 full bit count", cap.size(), 256);
    chk("R3 last payload byte", cap_byte(15), 8'(15 * 17 + 1));
    rd(A_TXQ, v); chk("R11 count back to zero", v, 0);
    for (int i = 0; i < 16; i++) begin
      rd(A_RXQ, v); chk("R8 ordered response", v, 8'(8'hF0 ^ (i * 3)));
    end
    rd(A_RXQ, v); chk("R8 pointer wrap", v, 8'hF0);

    // clear rewinds both pointers
    wr(A_TXQ, 8'h44); wr(A_TXQ, 8'h55); wr(A_TXQ, 8'h66);
    rd(A_RXQ, v); chk("R8 second entry", v, 8'hF3);
    wr(A_CTRL, 8'h02);
    rd(A_TXQ, v);  chk("R10 queue emptied", v, 0);
    rd(A_RXQ, v);  chk("R10 read pointer rewound", v, 8'hF0);
    rd(A_CTRL, v); chk("R10 clear bit reads 0", v, 8'h00);
    wr(A_TXQ, 8'h9F); wr(A_LEN, 8'h00);
    cap.delete();
    wr(A_CTRL, 8'h05);
    wait_idle();
    chk("R10 new command byte first", cap_byte(0), 8'h9F);

    repeat (4) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule